// File: doc/BRIEF.md
# Memory Fault Interrupt Capture

This block sits beside a memory controller and records faults that the controller has already detected. Three fault sources feed it, and each one arrives as a one-cycle strobe together with its attributes. The sources are an address that decodes to no target, an access through an invalid translation-table page, and an access that breaks the security rules. For each source the block holds one pending bit and a pair of capture registers. The first word of the pair packs the client number, the access direction and, where the source has them, the secure flag and the violation type. The second word holds the faulting address.

Software reads the pending bits, masks them with an enable register and clears them by writing ones. One interrupt line is high while any pending bit is set with its enable bit set. A source's capture pair stays frozen from its first fault until software clears that source's pending bit, so the first fault is the one software sees. A fault that lands in the same cycle as the clear wins over the clear and is captured.

The register port is a plain select/write bus with byte offsets and combinational read data. Offsets below are byte offsets. Each capture pair occupies two adjacent words, with the address word directly after the status word.

Top module: `memfault_irq`

## Requirements
- R1: After a synchronous active-low reset, the pending register (0x00), the enable register (0x04) and all capture registers read 0, and `irq` is low.
- R2: A strobe on a source sets its pending bit in the register at 0x00 on the next clock edge. Bit 0 is the decode fault, bit 1 the page fault and bit 2 the security fault.
- R3: A write to 0x00 clears every pending bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R4: The enable register at 0x04 is read/write in bits [2:0], which use the same bit order as the pending bits. `irq` is high exactly when some pending bit has its enable bit set.
- R5: The decode-fault capture status at 0x10 holds the client in bits [5:0], the write flag in bit 16 and the secure flag in bit 17. Its faulting address is at 0x14.
- R6: The page-fault capture status at 0x18 holds the write flag in bit 0 and the client in bits [6:1]. Its address is at 0x1C.
- R7: The security-fault capture status at 0x20 holds the client in bits [5:0], the write flag in bit 16, the secure flag in bit 17 and the violation type in bit 30. Its address is at 0x24.
- R8: While a source's pending bit is set, further faults from that source leave both of its capture registers unchanged.
- R9: A fault in the same cycle as a write that clears its pending bit leaves the bit set and captures that fault's attributes and address.
- R10: Writes to capture registers and to unused offsets have no effect. Reads of unused or misaligned offsets return 0. Enable bits above bit 2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offset | input | OFS_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| dec_fire | input | 1 | Decode-fault strobe |
| dec_client | input | 6 | Client of the decode fault |
| dec_write | input | 1 | Decode fault was a write |
| dec_secure | input | 1 | Decode fault was a secure access |
| dec_addr | input | ADDR_W | Decode fault address |
| pg_fire | input | 1 | Page-fault strobe |
| pg_client | input | 6 | Client of the page fault |
| pg_write | input | 1 | Page fault was a write |
| pg_addr | input | ADDR_W | Page fault address |
| sv_fire | input | 1 | Security-fault strobe |
| sv_client | input | 6 | Client of the security fault |
| sv_write | input | 1 | Security fault was a write |
| sv_secure | input | 1 | Security fault was a secure access |
| sv_kind | input | 1 | Violation type |
| sv_addr | input | ADDR_W | Security fault address |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that a strobe sets its pending bit and that a written one clears a bit unless a fault collides with it. They also check that zeros in the write data keep pending bits, that the enable register takes the written value, that a set pending bit freezes its capture pair, and that the interrupt never rises without a pending bit. Only the bench's scenarios can show that each source packs its fields at the right bit positions and that each pair sits at its stated offsets. The same holds for keeping the first fault and not a later one, for capturing the colliding fault on a same-cycle clear, and for ignoring writes to capture and unused offsets.

// File: rtl/memfault_pkg.sv
// Package: shared constants, field positions and types for the memory
// fault capture block. Assumes a 32-bit register word.
package memfault_pkg;
    localparam int unsigned NUM_SRC  = 3;
    localparam int unsigned CID_W    = 6;
    localparam int unsigned DATA_W   = 32;

    // pending-bit index per source
    localparam int SRC_DEC  = 0;
    localparam int SRC_PAGE = 1;
    localparam int SRC_SEC  = 2;

    // status field positions (low-id layout)
    localparam int DIR_BIT   = 16;
    localparam int SEC_BIT   = 17;
    localparam int KIND_BIT  = 30;
    // status field positions (shifted-id layout)
    localparam int PG_DIR_BIT = 0;
    localparam int PG_ID_LSB  = 1;

    // byte offsets
    localparam int OFS_PEND    = 'h00;
    localparam int OFS_ENABLE  = 'h04;
    localparam int OFS_CAP     = 'h10;
    localparam int CAP_STRIDE  = 8;
    localparam int CAP_ADDR_OFS = 4;

    typedef enum logic [1:0] {
        FMT_DECODE   = 2'd0,
        FMT_PAGE     = 2'd1,
        FMT_SECURITY = 2'd2
    } fmt_e;

    typedef struct packed {
        logic [CID_W-1:0] cid;
        logic             wr;
        logic             sec;
        logic             kind;
    } fault_attr_t;
endpackage

// File: rtl/memfault_slot.sv
// Module: one capture pair (status word + address word) for a fault source.
// The FMT parameter picks the status field layout. Assumes ADDR_W <= 32.
// Captures when a fault arrives and the source is not holding.
module memfault_slot
    import memfault_pkg::*;
#(
    parameter fmt_e        FMT    = FMT_DECODE,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              hold,
    input  fault_attr_t       attr,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] cap_status,
    output logic [DATA_W-1:0] cap_addr
);
    logic [DATA_W-1:0] status_w;
    logic              cap_en;

    assign cap_en = fire && !hold;

    generate
        if (FMT == FMT_PAGE) begin : g_shift_id
            // Pack direction at bit 0 and client id from bit 1.
            always_comb begin
                status_w = '0;
                status_w[PG_DIR_BIT] = attr.wr;
                status_w[PG_ID_LSB +: CID_W] = attr.cid;
            end
        end else begin : g_low_id
            // Pack client id low, flags high, type bit for security only.
            always_comb begin
                status_w = '0;
                status_w[0 +: CID_W] = attr.cid;
                status_w[DIR_BIT]    = attr.wr;
                status_w[SEC_BIT]    = attr.sec;
                if (FMT == FMT_SECURITY) status_w[KIND_BIT] = attr.kind;
            end
        end
    endgenerate

    // Capture register pair, frozen while holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_status <= '0;
            cap_addr   <= '0;
        end else if (cap_en) begin
            cap_status <= status_w;
            cap_addr   <= DATA_W'(addr);
        end
    end

    a_r8_frozen_pair: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(cap_status) && $stable(cap_addr)));

    a_r9_capture_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !hold) |=> (cap_addr == DATA_W'($past(addr))));
endmodule

// File: rtl/memfault_irq_regs.sv
// Module: pending bits (set by faults, write-one-to-clear), enable mask and
// the interrupt output. A fault wins over a same-cycle clear. hold tells
// each capture slot whether its pending bit stays set this cycle.
module memfault_irq_regs
    import memfault_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fault,
    input  logic         wr_pend,
    input  logic         wr_enable,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] en_q,
    output logic [N-1:0] hold,
    output logic         irq
);
    logic [N-1:0] clr;

    assign clr  = wr_pend ? wbits : '0;
    assign hold = pend_q & ~clr;
    assign irq  = |(pend_q & en_q);

    // Pending bits: clear on written ones, set on fault.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | fault;
    end

    // Enable mask, plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= '0;
        else if (wr_enable) en_q <= wbits;
    end

    a_r2_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault) |=> ((pend_q & $past(fault)) == $past(fault)));

    a_r3_ones_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ((pend_q & $past(wbits) & ~$past(fault)) == '0));

    a_r3_zeros_keep: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ($past(pend_q) & ~($past(wr_pend) ? $past(wbits) : '0)))
                  == ($past(pend_q) & ~($past(wr_pend) ? $past(wbits) : '0))));

    a_r4_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enable |=> (en_q == $past(wbits)));

    a_r4_no_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
endmodule

// File: rtl/memfault_bus_port.sv
// Module: register port decode. Makes the write strobes for the pending and
// enable registers and muxes read data. Capture words are read only.
// Unused and misaligned offsets read 0.
module memfault_bus_port
    import memfault_pkg::*;
#(
    parameter int unsigned N     = NUM_SRC,
    parameter int unsigned OFS_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel,
    input  logic                    wr,
    input  logic [OFS_W-1:0]        offset,
    input  logic [N-1:0]            pend,
    input  logic [N-1:0]            en,
    input  logic [N-1:0][DATA_W-1:0] cap_status,
    input  logic [N-1:0][DATA_W-1:0] cap_addr,
    output logic                    wr_pend,
    output logic                    wr_enable,
    output logic [DATA_W-1:0]       rdata
);
    assign wr_pend   = sel && wr && (offset == OFS_W'(OFS_PEND));
    assign wr_enable = sel && wr && (offset == OFS_W'(OFS_ENABLE));

    // Read mux over pending, enable and every capture pair.
    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            if (offset == OFS_W'(OFS_PEND))   rdata = DATA_W'(pend);
            if (offset == OFS_W'(OFS_ENABLE)) rdata = DATA_W'(en);
            for (int i = 0; i < int'(N); i++) begin
                if (offset == OFS_W'(OFS_CAP + CAP_STRIDE * i))
                    rdata = cap_status[i];
                if (offset == OFS_W'(OFS_CAP + CAP_STRIDE * i + CAP_ADDR_OFS))
                    rdata = cap_addr[i];
            end
        end
    end

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !wr) |-> (rdata == '0));

    a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_pend, wr_enable}));
endmodule

// File: rtl/memfault_irq.sv
// Module: top of the memory fault capture block. Three fault sources, each
// with a capture pair, a shared pending/enable register pair and one irq.
// Assumes faults arrive as single-cycle strobes with stable attributes.
module memfault_irq
    import memfault_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [OFS_W-1:0]  bus_offset,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dec_fire,
    input  logic [5:0]        dec_client,
    input  logic              dec_write,
    input  logic              dec_secure,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic              pg_fire,
    input  logic [5:0]        pg_client,
    input  logic              pg_write,
    input  logic [ADDR_W-1:0] pg_addr,
    input  logic              sv_fire,
    input  logic [5:0]        sv_client,
    input  logic              sv_write,
    input  logic              sv_secure,
    input  logic              sv_kind,
    input  logic [ADDR_W-1:0] sv_addr,
    output logic              irq
);
    localparam int unsigned N = NUM_SRC;

    logic [N-1:0]               fire;
    logic [N-1:0]               hold;
    logic [N-1:0]               pend_q;
    logic [N-1:0]               en_q;
    fault_attr_t                attr   [N];
    logic [ADDR_W-1:0]          faddr  [N];
    logic [N-1:0][DATA_W-1:0]   cap_status;
    logic [N-1:0][DATA_W-1:0]   cap_addr;
    logic                       wr_pend;
    logic                       wr_enable;

    // Gather per-source inputs into indexed form.
    always_comb begin
        fire[SRC_DEC]  = dec_fire;
        fire[SRC_PAGE] = pg_fire;
        fire[SRC_SEC]  = sv_fire;
        attr[SRC_DEC]  = '{cid: dec_client, wr: dec_write, sec: dec_secure, kind: 1'b0};
        attr[SRC_PAGE] = '{cid: pg_client,  wr: pg_write,  sec: 1'b0,       kind: 1'b0};
        attr[SRC_SEC]  = '{cid: sv_client,  wr: sv_write,  sec: sv_secure,  kind: sv_kind};
        faddr[SRC_DEC]  = dec_addr;
        faddr[SRC_PAGE] = pg_addr;
        faddr[SRC_SEC]  = sv_addr;
    end

    memfault_irq_regs #(.N(N)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault     (fire),
        .wr_pend   (wr_pend),
        .wr_enable (wr_enable),
        .wbits     (bus_wdata[N-1:0]),
        .pend_q    (pend_q),
        .en_q      (en_q),
        .hold      (hold),
        .irq       (irq)
    );

    generate
        for (genvar i = 0; i < int'(N); i++) begin : g_slot
            localparam fmt_e F = (i == SRC_DEC)  ? FMT_DECODE :
                                 (i == SRC_PAGE) ? FMT_PAGE : FMT_SECURITY;
            memfault_slot #(.FMT(F), .ADDR_W(ADDR_W)) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .fire       (fire[i]),
                .hold       (hold[i]),
                .attr       (attr[i]),
                .addr       (faddr[i]),
                .cap_status (cap_status[i]),
                .cap_addr   (cap_addr[i])
            );
        end
    endgenerate

    memfault_bus_port #(.N(N), .OFS_W(OFS_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (bus_sel),
        .wr         (bus_write),
        .offset     (bus_offset),
        .pend       (pend_q),
        .en         (en_q),
        .cap_status (cap_status),
        .cap_addr   (cap_addr),
        .wr_pend    (wr_pend),
        .wr_enable  (wr_enable),
        .rdata      (bus_rdata)
    );

    a_r4_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_q != '0));
endmodule

// File: tb/memfault_irq_bench.sv
// Bench: a table of fault vectors walked by one loop, then directed tests.
module memfault_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_offset = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dec_fire = 0, dec_write = 0, dec_secure = 0;
    logic [5:0]  dec_client = '0;
    logic [31:0] dec_addr = '0;
    logic        pg_fire = 0, pg_write = 0;
    logic [5:0]  pg_client = '0;
    logic [31:0] pg_addr = '0;
    logic        sv_fire = 0, sv_write = 0, sv_secure = 0, sv_kind = 0;
    logic [5:0]  sv_client = '0;
    logic [31:0] sv_addr = '0;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    always #5 clk = ~clk;

    memfault_irq u_memfault_irq (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_write(bus_write), .bus_offset(bus_offset),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dec_fire(dec_fire), .dec_client(dec_client), .dec_write(dec_write),
        .dec_secure(dec_secure), .dec_addr(dec_addr),
        .pg_fire(pg_fire), .pg_client(pg_client), .pg_write(pg_write), .pg_addr(pg_addr),
        .sv_fire(sv_fire), .sv_client(sv_client), .sv_write(sv_write),
        .sv_secure(sv_secure), .sv_kind(sv_kind), .sv_addr(sv_addr),
        .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  src;
        logic [5:0]  cid;
        logic        wr;
        logic        sec;
        logic        kind;
        logic [31:0] addr;
        logic [31:0] sts;
    } vec_t;

    // Expected status words follow R5, R6 and R7 field positions.
    localparam vec_t VEC [0:5] = '{
        '{2'd0, 6'h2A, 1'b1, 1'b0, 1'b0, 32'h8000_1000, 32'h0001_002A},
        '{2'd1, 6'h15, 1'b0, 1'b1, 1'b0, 32'h0000_2004, 32'h0000_002A},
        '{2'd2, 6'h3F, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFC, 32'h4003_003F},
        '{2'd0, 6'h01, 1'b0, 1'b1, 1'b1, 32'h1234_5678, 32'h0002_0001},
        '{2'd1, 6'h3F, 1'b1, 1'b0, 1'b1, 32'hDEAD_BEE0, 32'h0000_007F},
        '{2'd2, 6'h00, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] ofs, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_write = 1; bus_offset = ofs; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_write = 0; bus_wdata = '0;
    endtask

    task automatic bus_rd(input logic [7:0] ofs, output logic [31:0] d);
        bus_sel = 1; bus_write = 0; bus_offset = ofs;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic set_fault(input logic [1:0] src, input logic [5:0] cid, input logic wr,
                             input logic sec, input logic kind, input logic [31:0] a);
        case (src)
            2'd0: begin dec_fire = 1; dec_client = cid; dec_write = wr; dec_secure = sec; dec_addr = a; end
            2'd1: begin pg_fire = 1; pg_client = cid; pg_write = wr; pg_addr = a; end
            default: begin sv_fire = 1; sv_client = cid; sv_write = wr; sv_secure = sec;
                           sv_kind = kind; sv_addr = a; end
        endcase
    endtask

    task automatic drop_faults();
        dec_fire = 0; pg_fire = 0; sv_fire = 0;
    endtask

    task automatic fault(input logic [1:0] src, input logic [5:0] cid, input logic wr,
                         input logic sec, input logic kind, input logic [31:0] a);
        @(negedge clk);
        set_fault(src, cid, wr, sec, kind, a);
        @(negedge clk);
        drop_faults();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        bus_rd(8'h00, d); check("R1 pending", d, 0);
        bus_rd(8'h04, d); check("R1 enable", d, 0);
        bus_rd(8'h10, d); check("R1 cap status", d, 0);
        bus_rd(8'h24, d); check("R1 cap addr", d, 0);
        check("R1 irq", {31'd0, irq}, 0);

        bus_wr(8'h04, 32'h7);

        // Vector loop: R2, R5/R6/R7, R4, R3
        for (int i = 0; i < 6; i++) begin
            logic [7:0] so;
            fault(VEC[i].src, VEC[i].cid, VEC[i].wr, VEC[i].sec, VEC[i].kind, VEC[i].addr);
            so = 8'h10 + 8'(8 * VEC[i].src);
            bus_rd(8'h00, d); check("R2 pending bit", d, 32'(1) << VEC[i].src);
            check("R4 irq on", {31'd0, irq}, 1);
            bus_rd(so, d);
            check(VEC[i].src == 0 ? "R5 status" : VEC[i].src == 1 ? "R6 status" : "R7 status",
                  d, VEC[i].sts);
            bus_rd(so + 8'h4, d);
            check(VEC[i].src == 0 ? "R5 addr" : VEC[i].src == 1 ? "R6 addr" : "R7 addr",
                  d, VEC[i].addr);
            bus_wr(8'h00, 32'(1) << VEC[i].src);
            bus_rd(8'h00, d); check("R3 cleared", d, 0);
            check("R4 irq off", {31'd0, irq}, 0);
        end

        // R8: first fault kept
        fault(2'd0, 6'h05, 1'b0, 1'b0, 1'b0, 32'h0000_0100);
        fault(2'd0, 6'h09, 1'b1, 1'b1, 1'b0, 32'h0000_0200);
        bus_rd(8'h10, d); check("R8 status kept", d, 32'h0000_0005);
        bus_rd(8'h14, d); check("R8 addr kept", d, 32'h0000_0100);

        // R9: fault colliding with clear
        @(negedge clk);
        bus_sel = 1; bus_write = 1; bus_offset = 8'h00; bus_wdata = 32'h1;
        set_fault(2'd0, 6'h0C, 1'b1, 1'b1, 1'b0, 32'h0000_0300);
        @(negedge clk);
        bus_sel = 0; bus_write = 0; bus_wdata = '0;
        drop_faults();
        bus_rd(8'h00, d); check("R9 bit stays", d, 32'h1);
        bus_rd(8'h10, d); check("R9 new status", d, 32'h0003_000C);
        bus_rd(8'h14, d); check("R9 new addr", d, 32'h0000_0300);

        // R3: zeros leave bits
        fault(2'd1, 6'h02, 1'b0, 1'b0, 1'b0, 32'h0000_0400);
        bus_wr(8'h00, 32'h2);
        bus_rd(8'h00, d); check("R3 zero keeps", d, 32'h1);
        bus_wr(8'h00, 32'h1);
        bus_rd(8'h00, d); check("R3 all clear", d, 0);

        // R4: masking
        bus_wr(8'h04, 32'h0);
        fault(2'd2, 6'h11, 1'b0, 1'b0, 1'b0, 32'h0000_0500);
        bus_rd(8'h00, d); check("R4 pending masked", d, 32'h4);
        check("R4 irq masked", {31'd0, irq}, 0);
        bus_wr(8'h04, 32'h4);
        check("R4 irq enabled", {31'd0, irq}, 1);
        bus_wr(8'h04, 32'h3);
        check("R4 irq other enables", {31'd0, irq}, 0);
        bus_wr(8'h00, 32'h4);

        // R10: ignored writes and unused reads
        bus_wr(8'h20, 32'hFFFF_FFFF);
        bus_rd(8'h20, d); check("R10 cap write ignored", d, 32'h0000_0011);
        bus_wr(8'h24, 32'hFFFF_FFFF);
        bus_rd(8'h24, d); check("R10 cap addr write ignored", d, 32'h0000_0500);
        bus_wr(8'h3C, 32'hFFFF_FFFF);
        bus_rd(8'h00, d); check("R10 unused write no pending", d, 0);
        bus_rd(8'h3C, d); check("R10 unused read", d, 0);
        bus_rd(8'h02, d); check("R10 misaligned read", d, 0);
        bus_wr(8'h04, 32'hFFFF_FFFF);
        bus_rd(8'h04, d); check("R10 enable upper bits", d, 32'h7);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule